// File: doc/BRIEF.md
# Configurable Timer/Counter Channel

This block is one timer/counter channel. The count is held in two byte registers, a low byte and a high byte. A 4-bit configuration field picks the counting source, whether an external level qualifies counting, and one of four count structures. In timer mode the channel counts a machine-cycle tick that is generated elsewhere. In counter mode it counts falling edges seen on an asynchronous event pin, after a two-flop synchroniser.

A separate run bit starts and stops counting. When the count wraps, a sticky overflow flag is set, and the interrupt logic around the block reads it. That logic clears the flag with a one-cycle acknowledge pulse. Software can also clear the flag by rewriting a count byte. Software reads and writes the count bytes through a small byte port. Bus address decoding is done outside this block.

Top module: `tmr_channel_top`

## Requirements
- R1: After a synchronous active-low reset, both count bytes read 0, the overflow flag is 0, the configuration is 0 and the run bit is 0.
- R2: `cfg_wdata` is written on `cfg_wr`. Bit 3 is the gate enable, bit 2 selects the source (0 = tick, 1 = event pin), and bits 1:0 select the mode. `run_wdata` is written on `run_wr`.
- R3: With source select 0 and counting enabled, the count advances by one on each clock in which `cycle_tick` is 1. The event pin has no effect.
- R4: With source select 1 and counting enabled, the count advances by one for each 1-to-0 transition of `ev_pin`, with each level held for at least 2 clocks. The event passes through a two-flop synchroniser, and `cycle_tick` has no effect.
- R5: Counting is enabled when run is 1 and either the gate bit is 0 or `gate_pin` is 1. Otherwise the count holds.
- R6: Mode 0 is a 13-bit counter. Low-byte bits 4:0 act as the low part, and a carry out of bit 4 increments the high byte. Low-byte bits 7:5 are never changed by counting. The counter wraps to 0 after 8192 counts.
- R7: Mode 1 is a 16-bit counter {high, low} that wraps to 0 after 65536 counts.
- R8: Mode 2 is an 8-bit counter in the low byte. On a count from 0xFF it loads the high byte, and the high byte is not changed.
- R9: Mode 3 is an 8-bit counter in the low byte that wraps from 0xFF to 0x00. The high byte is not changed.
- R10: Every wrap or reload sets `ovf_flag` on the same clock edge that updates the count. The flag stays set until an `ovf_ack` pulse or a count-byte write clears it. A wrap in the same cycle as `ovf_ack` leaves the flag set.
- R11: `reg_wr` writes `reg_wdata` into the low byte (`reg_addr` = 0) or the high byte (`reg_addr` = 1). Counting is suppressed in the write cycle. `reg_rdata` shows the addressed byte combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cycle_tick | input | 1 | Machine-cycle tick, counted in timer mode |
| ev_pin | input | 1 | Asynchronous external event input |
| gate_pin | input | 1 | Gating level, synchronous to clk |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Configuration {gate, source, mode[1:0]} |
| run_wr | input | 1 | Run bit write strobe |
| run_wdata | input | 1 | New run bit value |
| reg_wr | input | 1 | Count byte write strobe |
| reg_addr | input | 1 | Byte select: 0 low, 1 high |
| reg_wdata | input | 8 | Count byte write data |
| reg_rdata | output | 8 | Addressed count byte |
| ovf_ack | input | 1 | Overflow acknowledge pulse |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The hardest case to reach from the ports is a wrap that lands in the same cycle as an acknowledge or a byte write. A full mode 0 or mode 1 run needs thousands of counts before it wraps. The stimulus therefore preloads the count bytes just below the wrap point, using random near-maximum values. It then runs random tick, gate and gate-pin patterns, and places directed acknowledge pulses on the exact wrap cycle. One directed run starts mode 0 from zero to confirm the 8192-count period.

// File: rtl/tmr_pkg.sv
// Package: shared types for the timer/counter channel.
// Assumes: the configuration field is 4 bits, laid out {gate, source, mode}.
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_13     = 2'd0,
        MODE_16     = 2'd1,
        MODE_RELOAD = 2'd2,
        MODE_8      = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic      gate_en;
        logic      ext_sel;
        tmr_mode_e mode;
    } tmr_cfg_t;
endpackage

// File: rtl/tmr_evsync.sv
// Module: tmr_evsync
// Synchronises an asynchronous event pin through a chain of flops.
// Emits a one-cycle pulse on each detected 1-to-0 transition.
// Assumes: the pin idles high, so reset loads ones to avoid a false edge.
module tmr_evsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Synchroniser chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Falling edge: previous synchronised level high, current low.
    assign fall = prev_q & ~sync_q[STAGES-1];

    AST_FALL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R4
endmodule

// File: rtl/tmr_count_core.sv
// Module: tmr_count_core
// Holds the low and high count bytes and advances them by one per step,
// following the selected mode structure. Reports a wrap or reload.
// Assumes: a byte write takes precedence and suppresses the step.
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int PRESC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_mode_e         mode,
    input  logic              step,
    input  logic              wr,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] lo,
    output logic [BYTE_W-1:0] hi,
    output logic              wrap
);
    localparam int CNT16_W = 2 * BYTE_W;
    localparam logic [PRESC_W-1:0] PRESC_MAX = '1;
    localparam logic [BYTE_W-1:0]  BYTE_MAX  = '1;

    logic [BYTE_W-1:0]  lo_nx, hi_nx;
    logic               at_max;
    logic [CNT16_W-1:0] cnt16_inc;

    assign cnt16_inc = {hi, lo} + CNT16_W'(1);

    // Next count value and terminal-count detect for the active mode.
    always_comb begin
        lo_nx  = lo;
        hi_nx  = hi;
        at_max = 1'b0;
        unique case (mode)
            MODE_13: begin
                at_max = (lo[PRESC_W-1:0] == PRESC_MAX) && (hi == BYTE_MAX);
                if (lo[PRESC_W-1:0] == PRESC_MAX) begin
                    lo_nx[PRESC_W-1:0] = '0;
                    hi_nx              = hi + BYTE_W'(1);
                end else begin
                    lo_nx[PRESC_W-1:0] = lo[PRESC_W-1:0] + PRESC_W'(1);
                end
            end
            MODE_16: begin
                at_max = ({hi, lo} == '1);
                {hi_nx, lo_nx} = cnt16_inc;
            end
            MODE_RELOAD: begin
                at_max = (lo == BYTE_MAX);
                lo_nx  = at_max ? hi : lo + BYTE_W'(1);
            end
            default: begin
                at_max = (lo == BYTE_MAX);
                lo_nx  = lo + BYTE_W'(1);
            end
        endcase
    end

    assign wrap = step & ~wr & at_max;

    // Count registers: write first, otherwise advance on a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo <= '0;
            hi <= '0;
        end else if (wr) begin
            if (wr_hi) hi <= wdata;
            else       lo <= wdata;
        end else if (step) begin
            lo <= lo_nx;
            hi <= hi_nx;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step && !wr |=> $stable(lo) && $stable(hi)); // R5
    AST_PRESC_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        step && !wr && mode == MODE_13 |=> lo[BYTE_W-1:PRESC_W] == $past(lo[BYTE_W-1:PRESC_W])); // R6
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        step && !wr && mode == MODE_RELOAD && lo == BYTE_MAX |=> lo == $past(hi) && $stable(hi)); // R8
    AST_MODE8_HI: assert property (@(posedge clk) disable iff (!rst_n)
        step && !wr && mode == MODE_8 |=> $stable(hi)); // R9
endmodule

// File: rtl/tmr_channel_top.sv
// Module: tmr_channel_top
// One timer/counter channel. It holds the configuration and run bit,
// qualifies the count source, keeps the sticky overflow flag, and
// provides byte access to the count.
// Assumes: gate_pin and cycle_tick are synchronous to clk; ev_pin is not.
module tmr_channel_top
    import tmr_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int PRESC_W    = 5,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cycle_tick,
    input  logic              ev_pin,
    input  logic              gate_pin,
    input  logic              cfg_wr,
    input  logic [3:0]        cfg_wdata,
    input  logic              run_wr,
    input  logic              run_wdata,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              ovf_ack,
    output logic              ovf_flag
);
    tmr_cfg_t          cfg_q;
    logic              run_q;
    logic              ev_fall;
    logic              count_en;
    logic              step;
    logic              wrap;
    logic [BYTE_W-1:0] cnt_lo, cnt_hi;

    // Configuration field and run bit storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            run_q <= 1'b0;
        end else begin
            if (cfg_wr) cfg_q <= tmr_cfg_t'(cfg_wdata);
            if (run_wr) run_q <= run_wdata;
        end
    end

    tmr_evsync #(.STAGES(SYNC_DEPTH)) u_evsync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ev_pin),
        .fall  (ev_fall)
    );

    assign count_en = run_q & (~cfg_q.gate_en | gate_pin);
    assign step     = count_en & (cfg_q.ext_sel ? ev_fall : cycle_tick);

    tmr_count_core #(.BYTE_W(BYTE_W), .PRESC_W(PRESC_W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (cfg_q.mode),
        .step  (step),
        .wr    (reg_wr),
        .wr_hi (reg_addr),
        .wdata (reg_wdata),
        .lo    (cnt_lo),
        .hi    (cnt_hi),
        .wrap  (wrap)
    );

    // Sticky overflow flag: setting wins over either clearing source.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ovf_flag <= 1'b0;
        else if (wrap)              ovf_flag <= 1'b1;
        else if (ovf_ack || reg_wr) ovf_flag <= 1'b0;
    end

    assign reg_rdata = reg_addr ? cnt_hi : cnt_lo;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_flag); // R10
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_ack && !wrap |=> !ovf_flag); // R10
    AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.gate_en && !gate_pin && !reg_wr |=> $stable(cnt_lo) && $stable(cnt_hi)); // R5
    AST_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q && !reg_wr |=> $stable(cnt_lo) && $stable(cnt_hi)); // R5
endmodule

// File: tb/tb_tmr_channel_top.sv
module tb_tmr_channel_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cycle_tick, ev_pin, gate_pin;
    logic       cfg_wr, run_wr, run_wdata, reg_wr, reg_addr, ovf_ack;
    logic [3:0] cfg_wdata;
    logic [7:0] reg_wdata, reg_rdata;
    logic       ovf_flag;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model state.
    logic [7:0] m_lo, m_hi;
    logic       m_flag, m_run, m_gate, m_ext;
    logic [1:0] m_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_channel_top dut (
        .clk(clk), .rst_n(rst_n), .cycle_tick(cycle_tick), .ev_pin(ev_pin),
        .gate_pin(gate_pin), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .run_wr(run_wr), .run_wdata(run_wdata), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ovf_ack(ovf_ack), .ovf_flag(ovf_flag)
    );

    // One count step of the model: returns {wrap, hi, lo}.
    function automatic logic [16:0] model_step(input logic [1:0] m,
                                               input logic [7:0] l,
                                               input logic [7:0] h);
        logic [7:0] nl, nh;
        logic       ov;
        nl = l; nh = h; ov = 1'b0;
        case (m)
            2'd0: begin
                if (l[4:0] == 5'h1f) begin
                    nl = {l[7:5], 5'd0}; nh = h + 8'd1; ov = (h == 8'hff);
                end else nl = l + 8'd1;
            end
            2'd1: begin
                {nh, nl} = {h, l} + 16'd1; ov = ({h, l} == 16'hffff);
            end
            2'd2: begin
                ov = (l == 8'hff); nl = ov ? h : l + 8'd1;
            end
            default: begin
                ov = (l == 8'hff); nl = l + 8'd1;
            end
        endcase
        return {ov, nh, nl};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One clock of stimulus, driven at negedge, model updated after posedge.
    task automatic cyc(input logic tick, input logic gp, input logic wr,
                       input logic a, input logic [7:0] d, input logic ack);
        logic [16:0] r;
        cycle_tick = tick; gate_pin = gp; reg_wr = wr; reg_addr = a;
        reg_wdata = d; ovf_ack = ack;
        @(posedge clk);
        if (wr) begin
            if (a) m_hi = d; else m_lo = d;
            m_flag = 1'b0;
        end else if (m_run && (!m_gate || gp) && !m_ext && tick) begin
            r = model_step(m_mode, m_lo, m_hi);
            {m_hi, m_lo} = r[15:0];
            if (r[16]) m_flag = 1'b1;
            else if (ack) m_flag = 1'b0;
        end else if (ack) m_flag = 1'b0;
        @(negedge clk);
        cycle_tick = 1'b0; reg_wr = 1'b0; ovf_ack = 1'b0;
    endtask

    task automatic set_cfg(input logic g, input logic e, input logic [1:0] m);
        cfg_wr = 1'b1; cfg_wdata = {g, e, m};
        @(posedge clk); @(negedge clk);
        cfg_wr = 1'b0;
        m_gate = g; m_ext = e; m_mode = m;
    endtask

    task automatic set_run(input logic v);
        run_wr = 1'b1; run_wdata = v;
        @(posedge clk); @(negedge clk);
        run_wr = 1'b0; m_run = v;
    endtask

    // One falling edge on the event pin, with ticks asserted to show they are ignored.
    task automatic ev_pulse(input logic gp);
        logic [16:0] r;
        gate_pin = gp; cycle_tick = 1'b1;
        ev_pin = 1'b0; repeat (3) @(negedge clk);
        ev_pin = 1'b1; repeat (3) @(negedge clk);
        cycle_tick = 1'b0;
        if (m_run && (!m_gate || gp)) begin
            r = model_step(m_mode, m_lo, m_hi);
            {m_hi, m_lo} = r[15:0];
            if (r[16]) m_flag = 1'b1;
        end
    endtask

    task automatic compare(input string req);
        reg_addr = 1'b0; #1;
        check(req, "low byte", {8'h0, reg_rdata}, {8'h0, m_lo});
        reg_addr = 1'b1; #1;
        check(req, "high byte", {8'h0, reg_rdata}, {8'h0, m_hi});
        check(req, "overflow flag", {15'h0, ovf_flag}, {15'h0, m_flag});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd1234;
        void'($urandom(seed));
        rst_n = 1'b0; cycle_tick = 0; ev_pin = 1; gate_pin = 0; cfg_wr = 0;
        cfg_wdata = 0; run_wr = 0; run_wdata = 0; reg_wr = 0; reg_addr = 0;
        reg_wdata = 0; ovf_ack = 0;
        m_lo = 0; m_hi = 0; m_flag = 0; m_run = 0; m_gate = 0; m_ext = 0; m_mode = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        // R1: the run bit resets to 0, so ticks do not count.
        repeat (5) cyc(1, 1, 0, 0, 0, 0);
        compare("R1");

        // R7: mode 1 wraps from 0xFFF0; the ack in the wrap cycle loses to the set (R10).
        set_cfg(0, 0, 2'd1);
        cyc(0, 0, 1, 1, 8'hff, 0);
        cyc(0, 0, 1, 0, 8'hf0, 0);
        set_run(1);
        repeat (15) cyc(1, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 1);
        compare("R10");
        cyc(0, 0, 0, 0, 0, 1);
        compare("R10");

        // R6: mode 0 from zero wraps after exactly 8192 ticks; bits 7:5 of the low byte are held.
        set_run(0);
        set_cfg(0, 0, 2'd0);
        cyc(0, 0, 1, 1, 8'h00, 0);
        cyc(0, 0, 1, 0, 8'ha0, 0);
        set_run(1);
        repeat (8191) cyc(1, 0, 0, 0, 0, 0);
        compare("R6");
        cyc(1, 0, 0, 0, 0, 0);
        compare("R6");
        check("R6", "wrap value", {ovf_flag, reg_rdata}, {1'b1, 8'h00});

        // R11: a byte write in a tick cycle replaces the byte and suppresses the count.
        set_cfg(0, 0, 2'd1);
        cyc(1, 0, 1, 0, 8'h55, 0);
        set_run(0);
        compare("R11");

        // R8: mode 2 reloads the low byte from the high byte.
        set_cfg(0, 0, 2'd2);
        cyc(0, 0, 1, 1, 8'h3c, 0);
        cyc(0, 0, 1, 0, 8'hfe, 0);
        set_run(1);
        repeat (3) cyc(1, 0, 0, 0, 0, 0);
        compare("R8");

        // R4/R3: counter mode counts pin edges and ignores ticks; R5: gating blocks edges.
        set_cfg(1, 1, 2'd3);
        repeat (4) ev_pulse(1);
        compare("R4");
        repeat (2) ev_pulse(0);
        compare("R5");

        // R9, R5, R3, R2: random runs near the wrap point with random gating.
        for (int it = 0; it < 300; it++) begin
            logic [1:0] md;
            logic       gt;
            md = 2'($urandom_range(0, 3));
            gt = 1'($urandom_range(0, 1));
            set_run(0);
            set_cfg(gt, 0, md);
            cyc(0, 0, 1, 1, 8'($urandom_range(250, 255)), 0);
            cyc(0, 0, 1, 0, 8'($urandom_range(200, 255)), 0);
            set_run(1'($urandom_range(0, 7) != 0));
            for (int k = 0; k < 40; k++)
                cyc(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 30) == 0), 1'($urandom_range(0, 1)),
                    8'($urandom), 1'($urandom_range(0, 9) == 0));
            case (md)
                2'd0: compare("R6");
                2'd1: compare("R7");
                2'd2: compare("R8");
                default: compare("R9");
            endcase
            if (gt) compare("R5"); else compare("R3");
        end
        compare("R2");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule